// File: doc/BRIEF.md
# Flash Block Protection Arbiter

This block rules on every program, erase and lock-type command sent to a flash array, one command per cycle. For each command it returns a registered accept/reject decision with an error code. It holds per-block write-protect and protect-freeze (lock-down) bits and a write-once selector that fixes one of four grouped regions as one-time programmable. It also tracks the suspend condition of the write state machine: idle, erase held, or program held.

Lock changes take effect at once while an erase is suspended, even on the block being erased. When that erase resumes, it is released to finish no matter what protection was applied in between. Any lock-type command that arrives while a program is suspended is refused. The placement of the small parameter blocks (low or high end of the array) is a static configuration pin, and it mirrors the one-time-programmable region map.

Top module: `flash_guard`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises: `lock_q` is all ones, `ldn_q` is all zeros, `susp_st` is 0, `err_sticky` is 0, `rsp_vld` is 0 and no region is one-time programmable.
- R2: A command presented with `cmd_vld` high produces `rsp_vld` high on the next cycle, with `rsp_acc` and `rsp_err`. Opcodes: 0 no-op, 1 program, 2 erase, 3 protect, 4 unprotect, 5 freeze, 6 select one-time region, 7 clear error. Error codes: 0 none, 1 protected, 2 one-time region, 3 program suspended, 4 frozen, 5 region already selected.
- R3: A program or erase to a block whose `lock_q` bit is 1 is rejected with code 1. A program or erase to an unprotected block outside the one-time region is accepted.
- R4: Once a region is selected, a program or erase to any block inside it is rejected with code 2, and this code wins over code 1. With `top_cfg`=0, region 0 is blocks 0..3 and region k (1..3) is block 3+k. With `top_cfg`=1, region 0 is blocks NBLK-4..NBLK-1 and region k is block NBLK-4-k.
- R5: Opcode 6 with no region selected is accepted and selects region `cmd_area`. Any later opcode 6 is rejected with code 5 and leaves the selection unchanged. Only reset clears the selection.
- R6: Protect sets the block's `lock_q` bit. Freeze sets both `lock_q` and `ldn_q`. Unprotect clears `lock_q` unless `ldn_q` is set, in which case it is rejected with code 4.
- R7: While `susp_st` is 1 (erase held), lock-type commands are accepted and change `lock_q`/`ldn_q` on the response cycle, including for the block whose erase is suspended.
- R8: While `susp_st` is 2 (program held), every lock-type command (opcodes 3, 4, 5) is rejected with code 3 and changes no `lock_q` or `ldn_q` bit.
- R9: A resume pulse while `susp_st` is 1 gives `rsm_go` high for one cycle on the next cycle. `rsm_blk` carries the block of the last erase accepted while idle, whatever its current protection.
- R10: `susp_st` encodes 0 idle, 1 erase held, 2 program held. From idle, an erase-suspend pulse gives 1 and a program-suspend pulse gives 2. From 1, a program-suspend pulse gives 2 (erase still held) and a resume pulse gives 0. From 2, a resume pulse returns to 1 if an erase was held beneath it, otherwise to 0.
- R11: A rejected program or erase sets `err_sticky`. Only an accepted opcode 7 clears it.
- R12: No command clears an `ldn_q` bit; only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| top_cfg | input | 1 | Parameter blocks at the high end when 1 |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode |
| cmd_blk | input | BW | Target block |
| cmd_area | input | 2 | Region number for opcode 6 |
| wsm_sus_erase | input | 1 | Erase-suspend pulse |
| wsm_sus_prog | input | 1 | Program-suspend pulse |
| wsm_resume | input | 1 | Resume pulse |
| rsp_vld | output | 1 | Decision valid |
| rsp_acc | output | 1 | Command accepted |
| rsp_err | output | 3 | Reject code |
| err_sticky | output | 1 | Sticky program/erase failure |
| lock_q | output | NBLK | Per-block protect bits |
| ldn_q | output | NBLK | Per-block freeze bits |
| susp_st | output | 2 | Suspend state |
| rsm_go | output | 1 | Suspended erase released |
| rsm_blk | output | BW | Block of released erase |

## Verification
Directed sequences place lock commands inside erase suspend, program suspend and nested suspend. These separate immediate application from refusal, and show that a resumed erase is released even after its block was protected. One-time region selection is exercised with both placements of the parameter blocks, which checks the mirrored map and the priority of code 2 over code 1. Long constrained-random runs then mix all eight opcodes with suspend and resume pulses. These reach freeze/unprotect conflicts, repeated selection attempts and sticky-error clearing in orders the directed cases do not.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_LOCK   = 3'd3,
    OP_UNLOCK = 3'd4,
    OP_FREEZE = 3'd5,
    OP_OTPSEL = 3'd6,
    OP_CLRERR = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    E_NONE   = 3'd0,
    E_PROT   = 3'd1,
    E_OTP    = 3'd2,
    E_PSUSP  = 3'd3,
    E_FROZEN = 3'd4,
    E_OTPSET = 3'd5
  } err_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ERS  = 2'd1,
    S_PRG  = 2'd2
  } sus_e;

  function automatic logic op_is_pe(op_e op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

  function automatic logic op_is_lock(op_e op);
    return (op == OP_LOCK) || (op == OP_UNLOCK) || (op == OP_FREEZE);
  endfunction

  // Region membership: index counted from the parameter end of the array.
  function automatic logic in_region(int nblk, logic top, logic [1:0] area, int blk);
    int idx;
    idx = top ? (nblk - 1 - blk) : blk;
    if (area == 2'd0) return idx < 4;
    return idx == (int'(area) + 3);
  endfunction

endpackage

// File: rtl/fg_otp_map.sv
module fg_otp_map
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 16
) (
  input  logic            top_cfg,
  input  logic            cfg_vld,
  input  logic [1:0]      area,
  output logic [NBLK-1:0] otp_mask
);
  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign otp_mask[i] = cfg_vld && in_region(NBLK, top_cfg, area, i);
  end
endmodule

// File: rtl/fg_susp_track.sv
module fg_susp_track
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BW = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sus_erase,
  input  logic          sus_prog,
  input  logic          resume,
  input  logic          erase_acc,
  input  logic [BW-1:0] erase_blk,
  output sus_e          st,
  output logic          rsm_go,
  output logic [BW-1:0] rsm_blk
);
  logic          ers_held;
  logic [BW-1:0] ers_blk;
  sus_e          st_nx;
  logic          held_nx;
  logic          ers_release;

  always_comb begin
    st_nx       = st;
    held_nx     = ers_held;
    ers_release = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (sus_erase)      st_nx = S_ERS;
        else if (sus_prog) begin st_nx = S_PRG; held_nx = 1'b0; end
      end
      S_ERS: begin
        if (sus_prog) begin st_nx = S_PRG; held_nx = 1'b1; end
        else if (resume) begin st_nx = S_IDLE; ers_release = 1'b1; end
      end
      S_PRG: begin
        if (resume) begin
          st_nx   = ers_held ? S_ERS : S_IDLE;
          held_nx = 1'b0;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ers_held <= 1'b0;
      ers_blk  <= '0;
      rsm_go   <= 1'b0;
      rsm_blk  <= '0;
    end else begin
      st       <= st_nx;
      ers_held <= held_nx;
      rsm_go   <= ers_release;
      if (ers_release) rsm_blk <= ers_blk;
      if (erase_acc && st == S_IDLE) ers_blk <= erase_blk;
    end
  end
endmodule

// File: rtl/fg_lock_bank.sv
module fg_lock_bank
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  op_e             op,
  input  logic [BW-1:0]   blk,
  output logic [NBLK-1:0] lock_q,
  output logic [NBLK-1:0] ldn_q
);
  for (genvar i = 0; i < NBLK; i++) begin : g_cell
    localparam logic [BW-1:0] IDX = BW'(i);
    logic hit;
    assign hit = wr_en && (blk == IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[i] <= 1'b1;
        ldn_q[i]  <= 1'b0;
      end else if (hit) begin
        unique case (op)
          OP_LOCK:   lock_q[i] <= 1'b1;
          OP_FREEZE: begin lock_q[i] <= 1'b1; ldn_q[i] <= 1'b1; end
          OP_UNLOCK: if (!ldn_q[i]) lock_q[i] <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fg_decide.sv
module fg_decide
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BW = $clog2(NBLK)
) (
  input  op_e             op,
  input  logic [BW-1:0]   blk,
  input  logic [NBLK-1:0] lock_q,
  input  logic [NBLK-1:0] ldn_q,
  input  logic [NBLK-1:0] otp_mask,
  input  logic            otp_cfg,
  input  sus_e            st,
  output logic            acc,
  output err_e            err
);
  logic blk_locked, blk_frozen, blk_otp;
  assign blk_locked = lock_q[blk];
  assign blk_frozen = ldn_q[blk];
  assign blk_otp    = otp_mask[blk];

  always_comb begin
    err = E_NONE;
    if (op_is_pe(op)) begin
      if (blk_otp)         err = E_OTP;
      else if (blk_locked) err = E_PROT;
    end else if (op_is_lock(op)) begin
      if (st == S_PRG)                          err = E_PSUSP;
      else if (op == OP_UNLOCK && blk_frozen)   err = E_FROZEN;
    end else if (op == OP_OTPSEL) begin
      if (otp_cfg) err = E_OTPSET;
    end
    acc = (err == E_NONE);
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int BW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            top_cfg,
  input  logic            cmd_vld,
  input  logic [2:0]      cmd_op,
  input  logic [BW-1:0]   cmd_blk,
  input  logic [1:0]      cmd_area,
  input  logic            wsm_sus_erase,
  input  logic            wsm_sus_prog,
  input  logic            wsm_resume,
  output logic            rsp_vld,
  output logic            rsp_acc,
  output logic [2:0]      rsp_err,
  output logic            err_sticky,
  output logic [NBLK-1:0] lock_q,
  output logic [NBLK-1:0] ldn_q,
  output logic [1:0]      susp_st,
  output logic            rsm_go,
  output logic [BW-1:0]   rsm_blk
);
  op_e             op;
  sus_e            st;
  logic            dec_acc;
  err_e            dec_err;
  logic            otp_cfg;
  logic [1:0]      otp_area;
  logic [NBLK-1:0] otp_mask;

  // Named internal events
  logic lock_wr, otp_wr, erase_acc, pe_reject, clr_hit;

  assign op        = op_e'(cmd_op);
  assign lock_wr   = cmd_vld && op_is_lock(op) && dec_acc;
  assign otp_wr    = cmd_vld && (op == OP_OTPSEL) && dec_acc;
  assign erase_acc = cmd_vld && (op == OP_ERASE) && dec_acc;
  assign pe_reject = cmd_vld && op_is_pe(op) && !dec_acc;
  assign clr_hit   = cmd_vld && (op == OP_CLRERR);
  assign susp_st   = st;

  fg_otp_map #(.NBLK(NBLK)) u_map (
    .top_cfg (top_cfg),
    .cfg_vld (otp_cfg),
    .area    (otp_area),
    .otp_mask(otp_mask)
  );

  fg_decide #(.NBLK(NBLK)) u_dec (
    .op      (op),
    .blk     (cmd_blk),
    .lock_q  (lock_q),
    .ldn_q   (ldn_q),
    .otp_mask(otp_mask),
    .otp_cfg (otp_cfg),
    .st      (st),
    .acc     (dec_acc),
    .err     (dec_err)
  );

  fg_lock_bank #(.NBLK(NBLK)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (lock_wr),
    .op    (op),
    .blk   (cmd_blk),
    .lock_q(lock_q),
    .ldn_q (ldn_q)
  );

  fg_susp_track #(.NBLK(NBLK)) u_sus (
    .clk      (clk),
    .rst_n    (rst_n),
    .sus_erase(wsm_sus_erase),
    .sus_prog (wsm_sus_prog),
    .resume   (wsm_resume),
    .erase_acc(erase_acc),
    .erase_blk(cmd_blk),
    .st       (st),
    .rsm_go   (rsm_go),
    .rsm_blk  (rsm_blk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld    <= 1'b0;
      rsp_acc    <= 1'b0;
      rsp_err    <= E_NONE;
      err_sticky <= 1'b0;
      otp_cfg    <= 1'b0;
      otp_area   <= 2'd0;
    end else begin
      rsp_vld <= cmd_vld;
      if (cmd_vld) begin
        rsp_acc <= dec_acc;
        rsp_err <= dec_err;
      end
      if (pe_reject)    err_sticky <= 1'b1;
      else if (clr_hit) err_sticky <= 1'b0;
      if (otp_wr) begin
        otp_cfg  <= 1'b1;
        otp_area <= cmd_area;
      end
    end
  end
endmodule

// File: rtl/fg_chk.sv
module fg_chk #(
  parameter int NBLK = 16,
  localparam int BW = $clog2(NBLK)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_vld,
  input logic [2:0]      cmd_op,
  input logic            wsm_sus_erase,
  input logic            wsm_sus_prog,
  input logic            wsm_resume,
  input logic            rsp_vld,
  input logic            rsp_acc,
  input logic [2:0]      rsp_err,
  input logic            err_sticky,
  input logic [NBLK-1:0] lock_q,
  input logic [NBLK-1:0] ldn_q,
  input logic [1:0]      susp_st,
  input logic            rsm_go,
  input logic            otp_cfg,
  input logic [1:0]      otp_area
);
  logic lk_cmd;
  assign lk_cmd = cmd_vld && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd5);

  AST_PSUSP_LOCK_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cmd && susp_st == 2'd2 |=> rsp_vld && !rsp_acc && rsp_err == 3'd3); // R8

  AST_PSUSP_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cmd && susp_st == 2'd2 |=> $stable(lock_q) && $stable(ldn_q)); // R8

  AST_FREEZE_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ldn_q) & ~ldn_q) == '0)); // R12

  AST_FREEZE_HOLDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ((ldn_q & ~lock_q) == '0)); // R6

  AST_OTP_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    otp_cfg |=> otp_cfg && $stable(otp_area)); // R5

  AST_ERASE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_resume && !wsm_sus_prog && susp_st == 2'd1 |=> rsm_go); // R9

  AST_STICKY_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && !rsp_acc && (rsp_err == 3'd1 || rsp_err == 3'd2) |-> err_sticky); // R11

  AST_RESP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> rsp_vld); // R2
endmodule

bind flash_guard fg_chk #(.NBLK(NBLK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_vld      (cmd_vld),
  .cmd_op       (cmd_op),
  .wsm_sus_erase(wsm_sus_erase),
  .wsm_sus_prog (wsm_sus_prog),
  .wsm_resume   (wsm_resume),
  .rsp_vld      (rsp_vld),
  .rsp_acc      (rsp_acc),
  .rsp_err      (rsp_err),
  .err_sticky   (err_sticky),
  .lock_q       (lock_q),
  .ldn_q        (ldn_q),
  .susp_st      (susp_st),
  .rsm_go       (rsm_go),
  .otp_cfg      (otp_cfg),
  .otp_area     (otp_area)
);

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  localparam int N  = 16;
  localparam int BW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic top_cfg = 1'b0;
  logic cmd_vld = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [BW-1:0] cmd_blk = '0;
  logic [1:0] cmd_area = 2'd0;
  logic wsm_sus_erase = 1'b0, wsm_sus_prog = 1'b0, wsm_resume = 1'b0;
  logic rsp_vld, rsp_acc, err_sticky, rsm_go;
  logic [2:0] rsp_err;
  logic [N-1:0] lock_q, ldn_q;
  logic [1:0] susp_st;
  logic [BW-1:0] rsm_blk;

  always #2.5 clk = ~clk;

  flash_guard #(.NBLK(N)) u0 (.*);

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [N-1:0] m_lock, m_ldn;
  bit m_cfg, m_sticky, m_held;
  logic [1:0] m_area, m_st;
  logic [BW-1:0] m_eblk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit m_otp(int blk);
    int lo, hi;
    if (!m_cfg) return 1'b0;
    if (!top_cfg) begin
      lo = (m_area == 0) ? 0 : 3 + m_area;
      hi = (m_area == 0) ? 3 : 3 + m_area;
    end else begin
      lo = (m_area == 0) ? N - 4 : N - 4 - m_area;
      hi = (m_area == 0) ? N - 1 : N - 4 - m_area;
    end
    return blk >= lo && blk <= hi;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_vld = 0; wsm_sus_erase = 0; wsm_sus_prog = 0; wsm_resume = 0;
    repeat (3) @(negedge clk);
    m_lock = '1; m_ldn = '0; m_cfg = 0; m_sticky = 0; m_held = 0;
    m_area = 0; m_st = 0; m_eblk = '0;
    chk("R1", "lock_q in reset", lock_q, m_lock);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lock_q", lock_q, m_lock);
    chk("R1", "ldn_q", ldn_q, '0);
    chk("R1", "susp_st", susp_st, 0);
    chk("R1", "err_sticky", err_sticky, 0);
    chk("R1", "rsp_vld", rsp_vld, 0);
  endtask

  task automatic do_cmd(int op, int blk, int area, string req);
    bit acc; int err;
    @(negedge clk);
    cmd_vld = 1; cmd_op = 3'(op); cmd_blk = BW'(blk); cmd_area = 2'(area);
    err = 0;
    if (op == 1 || op == 2) begin
      if (m_otp(blk)) err = 2;
      else if (m_lock[blk]) err = 1;
      if (err != 0) m_sticky = 1;
      else if (op == 2 && m_st == 0) m_eblk = BW'(blk);
    end else if (op >= 3 && op <= 5) begin
      if (m_st == 2) err = 3;
      else if (op == 4 && m_ldn[blk]) err = 4;
      else if (op == 3) m_lock[blk] = 1;
      else if (op == 5) begin m_lock[blk] = 1; m_ldn[blk] = 1; end
      else m_lock[blk] = 0;
    end else if (op == 6) begin
      if (m_cfg) err = 5;
      else begin m_cfg = 1; m_area = 2'(area); end
    end else if (op == 7) m_sticky = 0;
    acc = (err == 0);
    @(negedge clk);
    cmd_vld = 0;
    chk(req, "rsp_vld", rsp_vld, 1);
    chk(req, "rsp_acc", rsp_acc, acc);
    chk(req, "rsp_err", rsp_err, err);
    chk(req, "lock_q", lock_q, m_lock);
    chk(req, "ldn_q", ldn_q, m_ldn);
    chk("R11", "err_sticky", err_sticky, m_sticky);
  endtask

  // ev: 0 erase suspend, 1 program suspend, 2 resume
  task automatic do_wsm(int ev, string req);
    bit go = 0;
    @(negedge clk);
    wsm_sus_erase = (ev == 0); wsm_sus_prog = (ev == 1); wsm_resume = (ev == 2);
    case (m_st)
      0: if (ev == 0) m_st = 1; else if (ev == 1) begin m_st = 2; m_held = 0; end
      1: if (ev == 1) begin m_st = 2; m_held = 1; end
         else if (ev == 2) begin m_st = 0; go = 1; end
      default: if (ev == 2) begin m_st = m_held ? 2'd1 : 2'd0; m_held = 0; end
    endcase
    @(negedge clk);
    wsm_sus_erase = 0; wsm_sus_prog = 0; wsm_resume = 0;
    chk("R10", "susp_st", susp_st, m_st);
    chk(req, "rsm_go", rsm_go, go);
    if (go) chk("R9", "rsm_blk", rsm_blk, m_eblk);
  endtask

  task automatic random_run(int cnt);
    for (int i = 0; i < cnt; i++) begin
      int r;
      r = $urandom % 10;
      if (r < 7) do_cmd($urandom % 8, $urandom % N, $urandom % 4, "R2");
      else do_wsm($urandom % 3, "R9");
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    top_cfg = 0;
    do_reset();
    do_cmd(2, 2, 0, "R3");          // protected erase refused
    do_cmd(7, 0, 0, "R11");
    do_cmd(4, 2, 0, "R6");
    do_cmd(2, 2, 0, "R3");          // erase accepted, recorded
    do_wsm(0, "R10");
    do_cmd(3, 2, 0, "R7");          // protect suspended block at once
    do_wsm(2, "R9");                // erase still released
    do_wsm(1, "R10");
    do_cmd(4, 5, 0, "R8");
    do_cmd(5, 7, 0, "R8");
    do_wsm(2, "R10");
    do_cmd(5, 6, 0, "R6");
    do_cmd(4, 6, 0, "R12");         // frozen: unprotect refused
    do_cmd(4, 1, 0, "R6");
    do_cmd(6, 0, 0, "R5");
    do_cmd(1, 1, 0, "R4");          // OTP wins
    do_cmd(1, 3, 0, "R4");          // protected and OTP -> code 2
    do_cmd(6, 0, 2, "R5");
    do_cmd(4, 4, 0, "R6");
    do_cmd(1, 4, 0, "R3");
    do_wsm(0, "R10");
    do_wsm(1, "R10");
    do_cmd(3, 4, 0, "R8");
    do_wsm(2, "R10");               // back to erase held
    do_cmd(3, 4, 0, "R7");
    do_wsm(2, "R9");
    random_run(1500);

    top_cfg = 1;
    do_reset();                     // R12: reset clears freeze
    do_cmd(6, 0, 1, "R5");
    do_cmd(4, N - 5, 0, "R6");
    do_cmd(1, N - 5, 0, "R4");      // region 1 at top -> block N-5
    do_cmd(4, N - 6, 0, "R6");
    do_cmd(1, N - 6, 0, "R3");
    do_cmd(4, 4, 0, "R6");
    do_cmd(2, 4, 0, "R4");          // not in top map
    random_run(1500);

    top_cfg = 1;
    do_reset();
    do_cmd(6, 0, 0, "R5");
    do_cmd(1, N - 1, 0, "R4");
    do_cmd(1, N - 4, 0, "R4");
    random_run(800);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule